// File: doc/BRIEF.md
# GPIO Interrupt Detect and Mask Unit

This unit turns the state of a set of already-synchronized GPIO inputs into interrupt requests. The inputs are grouped in banks of `BANK_W` pins. Each pin has its own settings. A trigger-kind bit chooses edge or level detection. A sense bit chooses rising/high or falling/low. A dual-edge bit makes an edge-mode pin fire on either transition. Every detected event is held in a sticky pending bit. Software clears a pending bit by writing a one to it.

A per-pin mask decides whether a pending bit reaches the single combined interrupt output. Software never writes the mask directly. One write-one port clears mask bits and a second write-one port sets them. Detection and pending capture carry on while a pin is masked, so a pin that is already pending raises the output as soon as it is unmasked. All registers sit on a simple memory-mapped bus. Writes take effect at the clock edge and reads are combinational.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mask bit is 1, and every pending, trigger-kind, sense and dual-edge bit is 0. `irqOut` is 0.
- R2: The mask of bank b is read at 0x20C+0x40*b, where bit value 1 means masked. Writing to 0x210+0x40*b clears each mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R3: Writing to 0x214+0x40*b sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: Trigger kind is set at 0x21C+0x40*b (1 = edge) and sense at 0x220+0x40*b. With edge mode and dual-edge 0, sense 1 latches on a 0-to-1 change and sense 0 latches on a 1-to-0 change. No other change latches.
- R5: Dual-edge is set at 0x224+0x40*b. With edge mode and dual-edge 1, both transitions latch and the sense bit is ignored.
- R6: In level mode (trigger kind 0), the pending bit is set in every cycle in which the pin equals its sense bit. The dual-edge bit has no effect in level mode.
- R7: Pending bits of bank b are read at 0x218+0x40*b and are sticky. A write there clears each bit whose data bit is 1. If a new event and a clear hit the same bit in the same cycle, the bit stays set, so a level pin cannot be cleared while its level is still active.
- R8: Pending bits are captured while the pin is masked. Clearing the mask bit of an already-pending pin asserts `irqOut` after the clock edge of that write.
- R9: `irqOut` is 1 exactly when some pin in any bank is both pending and unmasked. A pin change seen at a clock edge updates the pending bit at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWdata | input | BANK_W | Write data |
| busRdata | output | BANK_W | Combinational read data for `busAddr` |
| pinIn | input | NUM_BANKS*BANK_W | Synchronized GPIO inputs, bank 0 in the low bits |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A table of pin settings and input transitions covers every pin mode. It includes rising, falling and both-edge selections driven with matching transitions, opposite transitions and no transition. These cases show whether the correct edge is decoded and whether the sense bit is really ignored in dual-edge mode. Level-mode entries hold the pin active or inactive before and after a clear. They show the difference between pending bits that stay sticky and bits that are re-set while the level remains. Directed sequences on a pin in a second bank then mask, unmask, re-mask and clear a pending event. These separate detection from propagation and show that zero data bits in the mask ports do nothing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Width of the bank selector carried in the strobe struct (up to 16 banks)
  localparam int BANK_SEL_W = 4;

  // Register window for bank b starts at BANK_BASE + b * 2**BANK_SPAN_LOG2
  localparam int BANK_BASE      = 512;
  localparam int BANK_SPAN_LOG2 = 6;

  localparam logic [5:0] OFS_MASK = 6'h0C;
  localparam logic [5:0] OFS_EN   = 6'h10;
  localparam logic [5:0] OFS_DIS  = 6'h14;
  localparam logic [5:0] OFS_STS  = 6'h18;
  localparam logic [5:0] OFS_KIND = 6'h1C;
  localparam logic [5:0] OFS_SENS = 6'h20;
  localparam logic [5:0] OFS_DUAL = 6'h24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_EN, SEL_DIS, SEL_STS, SEL_KIND, SEL_SENS, SEL_DUAL
  } regSel_e;

  typedef struct packed {
    logic                  wr;
    logic [BANK_SEL_W-1:0] bank;
    regSel_e               sel;
  } accStb_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output accStb_t           stb
);

  localparam int BF_W = ADDR_W - BANK_SPAN_LOG2;

  logic [ADDR_W-1:0] rel;
  logic [BF_W-1:0]   bankField;
  logic              inRange;

  always_comb begin
    stb       = '0;
    rel       = busAddr - ADDR_W'(BANK_BASE);
    bankField = rel[ADDR_W-1:BANK_SPAN_LOG2];
    inRange   = (busAddr >= ADDR_W'(BANK_BASE)) && (bankField < BF_W'(NUM_BANKS));
    if (inRange) begin
      stb.bank = BANK_SEL_W'(bankField);
      case (rel[BANK_SPAN_LOG2-1:0])
        OFS_MASK: stb.sel = SEL_MASK;
        OFS_EN:   stb.sel = SEL_EN;
        OFS_DIS:  stb.sel = SEL_DIS;
        OFS_STS:  stb.sel = SEL_STS;
        OFS_KIND: stb.sel = SEL_KIND;
        OFS_SENS: stb.sel = SEL_SENS;
        OFS_DUAL: stb.sel = SEL_DUAL;
        default:  stb.sel = SEL_NONE;
      endcase
    end
    // the mask view is read-only; writes to it are dropped
    stb.wr = busWe && (stb.sel != SEL_NONE) && (stb.sel != SEL_MASK);
  end

endmodule

// File: rtl/gpio_irq_bank_array.sv
module gpio_irq_bank_array
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  accStb_t                     stb,
  input  logic [BANK_W-1:0]           wdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0]           rdata,
  output logic [NUM_BANKS*BANK_W-1:0] stsAll,
  output logic [NUM_BANKS*BANK_W-1:0] maskAll,
  output logic                        irqPend
);

  localparam int TOTAL_W = NUM_BANKS * BANK_W;

  logic [TOTAL_W-1:0] pinPrev;
  logic               prevValid;
  logic [TOTAL_W-1:0] kindAll, sensAll, dualAll;

  // one cycle of pin history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev   <= '0;
      prevValid <= 1'b0;
    end else begin
      pinPrev   <= pinIn;
      prevValid <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;

    logic              hit;
    logic [BANK_W-1:0] cur, prv, rise, fall, edgeEvt, lvlEvt, evt, clrBits;
    logic [BANK_W-1:0] kindR, sensR, dualR, maskR, stsR;

    assign hit  = stb.wr && (stb.bank == BANK_SEL_W'(b));
    assign cur  = pinIn[LO +: BANK_W];
    assign prv  = pinPrev[LO +: BANK_W];
    assign rise = cur & ~prv & {BANK_W{prevValid}};
    assign fall = ~cur & prv & {BANK_W{prevValid}};

    assign edgeEvt = (dualR & (rise | fall))
                   | (~dualR & ((sensR & rise) | (~sensR & fall)));
    assign lvlEvt  = ~(cur ^ sensR);
    assign evt     = (kindR & edgeEvt) | (~kindR & lvlEvt);
    assign clrBits = (hit && stb.sel == SEL_STS) ? wdata : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        kindR <= '0;
        sensR <= '0;
        dualR <= '0;
        maskR <= '1;
        stsR  <= '0;
      end else begin
        if (hit && stb.sel == SEL_KIND) kindR <= wdata;
        if (hit && stb.sel == SEL_SENS) sensR <= wdata;
        if (hit && stb.sel == SEL_DUAL) dualR <= wdata;
        if (hit && stb.sel == SEL_EN)       maskR <= maskR & ~wdata;
        else if (hit && stb.sel == SEL_DIS) maskR <= maskR | wdata;
        // a fresh event outranks a same-cycle clear
        stsR <= (stsR & ~clrBits) | evt;
      end
    end

    assign kindAll[LO +: BANK_W] = kindR;
    assign sensAll[LO +: BANK_W] = sensR;
    assign dualAll[LO +: BANK_W] = dualR;
    assign maskAll[LO +: BANK_W] = maskR;
    assign stsAll[LO +: BANK_W]  = stsR;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stb.bank == BANK_SEL_W'(b)) begin
        case (stb.sel)
          SEL_MASK: rdata = maskAll[b*BANK_W +: BANK_W];
          SEL_STS:  rdata = stsAll[b*BANK_W +: BANK_W];
          SEL_KIND: rdata = kindAll[b*BANK_W +: BANK_W];
          SEL_SENS: rdata = sensAll[b*BANK_W +: BANK_W];
          SEL_DUAL: rdata = dualAll[b*BANK_W +: BANK_W];
          default:  rdata = '0;
        endcase
      end
    end
  end

  assign irqPend = |(stsAll & ~maskAll);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWe,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [BANK_W-1:0]           busWdata,
  output logic [BANK_W-1:0]           busRdata,
  input  logic [NUM_BANKS*BANK_W-1:0] pinIn,
  output logic                        irqOut
);

  accStb_t                     stb;
  logic [NUM_BANKS*BANK_W-1:0] stsAll;
  logic [NUM_BANKS*BANK_W-1:0] maskAll;

  gpio_irq_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_irq_bank_array #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .stsAll  (stsAll),
    .maskAll (maskAll),
    .irqPend (irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 12
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busWe,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [BANK_W-1:0]           busWdata,
  input logic                        irqOut,
  input logic [NUM_BANKS*BANK_W-1:0] stsAll,
  input logic [NUM_BANKS*BANK_W-1:0] maskAll
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (maskAll == '1 && stsAll == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskAll == '1) |-> !irqOut);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsAll == '0) |-> !irqOut);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam int LO = b * BANK_W;
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(512 + 64 * b + 16);
    localparam logic [ADDR_W-1:0] DIS_A = ADDR_W'(512 + 64 * b + 20);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(512 + 64 * b + 24);

    // R2
    unmask_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == EN_A) |=>
        ((maskAll[LO +: BANK_W] & $past(busWdata)) == '0));

    // R2
    unmask_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == EN_A) |=>
        ((maskAll[LO +: BANK_W] & ~$past(busWdata)) ==
         ($past(maskAll[LO +: BANK_W]) & ~$past(busWdata))));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && busAddr == DIS_A) |=>
        (maskAll[LO +: BANK_W] == ($past(maskAll[LO +: BANK_W]) | $past(busWdata))));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(busWe && busAddr == STS_A) |=>
        ((stsAll[LO +: BANK_W] & $past(stsAll[LO +: BANK_W])) == $past(stsAll[LO +: BANK_W])));
  end

endmodule

bind gpio_irq_unit gpio_irq_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .irqOut   (irqOut),
  .stsAll   (stsAll),
  .maskAll  (maskAll)
);

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;

  localparam int NUM_BANKS = 2;
  localparam int BANK_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NVEC      = 13;

  localparam int O_MASK = 12, O_EN = 16, O_DIS = 20, O_STS = 24;
  localparam int O_KIND = 28, O_SENS = 32, O_DUAL = 36;

  // {kind, sense, dual, pinBefore, pinAfter, expectedPending}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110_01_1,  // R4 rising seen
    6'b110_10_0,  // R4 falling ignored in rising mode
    6'b100_10_1,  // R4 falling seen
    6'b100_01_0,  // R4 rising ignored in falling mode
    6'b101_01_1,  // R5 dual edge, sense 0, rising
    6'b111_10_1,  // R5 dual edge, sense 1, falling
    6'b110_11_0,  // R4 steady high, no edge
    6'b010_01_1,  // R6 level high reached
    6'b010_10_1,  // R6 R7 active during clear, set wins
    6'b011_00_0,  // R6 dual ignored in level mode
    6'b000_10_1,  // R6 level low reached
    6'b000_11_0,  // R6 level low never active
    6'b001_11_0   // R6 dual ignored, low never active
  };

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic                        busWe = 1'b0;
  logic [ADDR_W-1:0]           busAddr = '0;
  logic [BANK_W-1:0]           busWdata = '0;
  logic [BANK_W-1:0]           busRdata;
  logic [NUM_BANKS*BANK_W-1:0] pinIn = '1;
  logic                        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [BANK_W-1:0] kindSh = '0, sensSh = '0, dualSh = '0;
  logic [BANK_W-1:0] rd;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .irqOut(irqOut)
  );

  function automatic logic [ADDR_W-1:0] regA(int bank, int ofs);
    return ADDR_W'(512 + 64 * bank + ofs);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [BANK_W-1:0] act,
                       input logic [BANK_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [BANK_W-1:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    // reset state, R1
    waitCyc(3);
    busRead(regA(0, O_MASK), rd); check(rd == '1, "R1 mask bank0", rd, '1);
    busRead(regA(1, O_MASK), rd); check(rd == '1, "R1 mask bank1", rd, '1);
    busRead(regA(0, O_STS), rd);  check(rd == '0, "R1 pending bank0", rd, '0);
    busRead(regA(1, O_KIND), rd); check(rd == '0, "R1 kind bank1", rd, '0);
    busRead(regA(0, O_SENS), rd); check(rd == '0, "R1 sense bank0", rd, '0);
    busRead(regA(0, O_DUAL), rd); check(rd == '0, "R1 dual bank0", rd, '0);
    check(irqOut == 1'b0, "R1 irqOut", BANK_W'(irqOut), '0);
    @(negedge clk); rstN = 1'b1;
    waitCyc(3);
    busRead(regA(0, O_STS), rd);  check(rd == '0, "R1 pending after release", rd, '0);

    // table of pin modes and transitions on bank 0 pins 0..12
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] e;
      e = VEC[v];
      @(negedge clk); pinIn[v] = e[2];
      waitCyc(2);
      kindSh[v] = e[5]; sensSh[v] = e[4]; dualSh[v] = e[3];
      busWrite(regA(0, O_KIND), kindSh);
      busWrite(regA(0, O_SENS), sensSh);
      busWrite(regA(0, O_DUAL), dualSh);
      waitCyc(2);
      busWrite(regA(0, O_STS), BANK_W'(1) << v);
      pinIn[v] = e[1];
      waitCyc(2);
      busRead(regA(0, O_STS), rd);
      check(rd[v] == e[0], $sformatf("R4/R5/R6 vector %0d pending", v),
            BANK_W'(rd[v]), BANK_W'(e[0]));
    end

    // R6 R7: held level cannot be cleared, released level can
    kindSh[25] = 1'b0; sensSh[25] = 1'b1;
    busWrite(regA(0, O_SENS), sensSh);
    waitCyc(2);
    busWrite(regA(0, O_STS), BANK_W'(1) << 25);
    waitCyc(1);
    busRead(regA(0, O_STS), rd);
    check(rd[25] == 1'b1, "R7 level held keeps pending", BANK_W'(rd[25]), 1);
    @(negedge clk); pinIn[25] = 1'b0;
    waitCyc(2);
    busWrite(regA(0, O_STS), BANK_W'(1) << 25);
    waitCyc(1);
    busRead(regA(0, O_STS), rd);
    check(rd[25] == 1'b0, "R7 cleared after level gone", BANK_W'(rd[25]), 0);

    // R8: bank 1 pin 20 rising edge while masked
    busWrite(regA(1, O_KIND), BANK_W'(1) << 20);
    busWrite(regA(1, O_SENS), BANK_W'(1) << 20);
    @(negedge clk); pinIn[BANK_W + 20] = 1'b0;
    waitCyc(2);
    pinIn[BANK_W + 20] = 1'b1;
    waitCyc(2);
    busRead(regA(1, O_STS), rd);
    check(rd == (BANK_W'(1) << 20), "R8 pending while masked", rd, BANK_W'(1) << 20);
    check(irqOut == 1'b0, "R8 masked output quiet", BANK_W'(irqOut), 0);

    busWrite(regA(1, O_EN), BANK_W'(1) << 20);
    busRead(regA(1, O_MASK), rd);
    check(rd == ~(BANK_W'(1) << 20), "R2 enable clears mask bit", rd, ~(BANK_W'(1) << 20));
    check(irqOut == 1'b1, "R8 unmask raises output", BANK_W'(irqOut), 1);

    busWrite(regA(1, O_EN), '0);
    busRead(regA(1, O_MASK), rd);
    check(rd == ~(BANK_W'(1) << 20), "R2 zero enable bits no effect", rd, ~(BANK_W'(1) << 20));
    busWrite(regA(1, O_MASK), '0);
    busRead(regA(1, O_MASK), rd);
    check(rd == ~(BANK_W'(1) << 20), "R2 mask view read-only", rd, ~(BANK_W'(1) << 20));

    busWrite(regA(1, O_DIS), BANK_W'(1) << 20);
    busRead(regA(1, O_MASK), rd);
    check(rd == '1, "R3 disable sets mask bit", rd, '1);
    check(irqOut == 1'b0, "R9 remasked output quiet", BANK_W'(irqOut), 0);
    busRead(regA(1, O_STS), rd);
    check(rd[20] == 1'b1, "R8 pending kept across remask", BANK_W'(rd[20]), 1);

    busWrite(regA(1, O_EN), BANK_W'(1) << 20);
    check(irqOut == 1'b1, "R9 output with one source", BANK_W'(irqOut), 1);
    busWrite(regA(1, O_STS), BANK_W'(1) << 20);
    busRead(regA(1, O_STS), rd);
    check(rd == '0, "R7 write-one clear", rd, '0);
    check(irqOut == 1'b0, "R9 output drops after clear", BANK_W'(irqOut), 0);

    done = 1'b1;
    summary();
  end

endmodule